// File: doc/BRIEF.md
# Configurable Two-Input Gate Array

A combinational grid of programmable logic cells. The grid has `ROWS` rows and `COLS` columns. Every cell takes two operands and produces one result bit. A 3-bit gene per cell selects what the cell does: it passes one of its operands through, or it applies one of six two-input Boolean functions. All genes are packed into a single flat genotype word.

The wiring between cells is fixed and cannot be changed. A cell in row `x` reads two signals from the previous column: the one in its own row and the one in row `x+1`. The bottom row wraps around and pairs with the top row. The first column applies the same rule directly to the primary input vector. The outputs are taken from chosen rows of the last column.

The block is intended for evaluating candidate circuit structures in hardware. A search engine outside the block loads a genotype, drives input patterns and compares the outputs against a target truth table. A parameter adds an output register, so a change of genotype or input appears at the ports after exactly one clock.

Top module: `cga_array`

## Requirements
- R1: A cell whose gene is 0 outputs its own-row operand unchanged.
- R2: A cell whose gene is 1 outputs its next-row operand unchanged.
- R3: Gene codes 2 through 7 produce the functions XOR, XNOR, NAND, NOR, AND and OR of the two operands, in that order.
- R4: The cell at row x of column c+1 takes its own-row operand from row x of column c. It takes its next-row operand from row (x+1) mod ROWS of column c, so the bottom row pairs with the top row.
- R5: Column 0 applies the rule of R4 to the primary inputs: row x reads `din[x]` and `din[(x+1) mod ROWS]`.
- R6: Gene i occupies `genotype[3i+2:3i]` and controls the cell at row i mod ROWS and column i div ROWS.
- R7: Output bit k is the result of row (OUT_SEL+k) mod ROWS in the last column. With the defaults (OUT_SEL=0, NUM_OUT=2), bit 0 is row 0 and bit 1 is row 1.
- R8: With REG_OUT=1, `dout` shows the result for the genotype and inputs present at the preceding rising clock edge. It does not change between edges.
- R9: A synchronous active-high `rst` clears the registered output to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| genotype | input | 3*ROWS*COLS | Packed genes, one 3-bit field per cell |
| din | input | ROWS | Primary input vector, one bit per row of column 0 |
| dout | output | NUM_OUT | Selected results from the last column |

## Verification
The genotype and the input vector can change in the same cycle. The output register must then capture the result of the new structure applied to the new operands, and never a mix of the old and new values. The bench updates both buses at the same falling edge, both in directed cases and in random ones. At the next falling edge it compares `dout` with a bench model evaluated on the new pair. It also checks, just after the update, that `dout` still holds the previous result.

// File: rtl/cga_pkg.sv
package cga_pkg;

    localparam int GENE_W = 3;

    typedef enum logic [GENE_W-1:0] {
        OP_PASS_OWN = 3'd0,
        OP_PASS_NBR = 3'd1,
        OP_XOR      = 3'd2,
        OP_XNOR     = 3'd3,
        OP_NAND     = 3'd4,
        OP_NOR      = 3'd5,
        OP_AND      = 3'd6,
        OP_OR       = 3'd7
    } gene_op_e;

    typedef struct packed {
        logic own;
        logic nbr;
    } cell_in_t;

    function automatic logic apply_gene(gene_op_e op, cell_in_t v);
        logic r;
        case (op)
            OP_PASS_OWN: r = v.own;
            OP_PASS_NBR: r = v.nbr;
            OP_XOR:      r = v.own ^ v.nbr;
            OP_XNOR:     r = ~(v.own ^ v.nbr);
            OP_NAND:     r = ~(v.own & v.nbr);
            OP_NOR:      r = ~(v.own | v.nbr);
            OP_AND:      r = v.own & v.nbr;
            OP_OR:       r = v.own | v.nbr;
            default:     r = v.own;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cga_cell.sv
module cga_cell
    import cga_pkg::*;
(
    input  logic [GENE_W-1:0] gene,
    input  logic              own_in,
    input  logic              nbr_in,
    output logic              res
);
    cell_in_t ops;

    always_comb begin
        ops.own = own_in;
        ops.nbr = nbr_in;
        res     = apply_gene(gene_op_e'(gene), ops);
    end
endmodule

// File: rtl/cga_column.sv
module cga_column
    import cga_pkg::*;
#(
    parameter int ROWS = 4,
    localparam int COL_GW = GENE_W * ROWS
) (
    input  logic [ROWS-1:0]   prev,
    input  logic [COL_GW-1:0] genes,
    output logic [ROWS-1:0]   nxt
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int NBR = (r + 1) % ROWS;
        cga_cell u_cell (
            .gene   (genes[r*GENE_W +: GENE_W]),
            .own_in (prev[r]),
            .nbr_in (prev[NBR]),
            .res    (nxt[r])
        );
    end
endmodule

// File: rtl/cga_out_stage.sv
module cga_out_stage #(
    parameter int W       = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (REG_OUT) begin : g_reg
        logic [W-1:0] q_r;
        always_ff @(posedge clk) begin
            if (rst) q_r <= '0;
            else     q_r <= d;
        end
        assign q = q_r;
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/cga_array.sv
module cga_array
    import cga_pkg::*;
#(
    parameter int ROWS    = 4,
    parameter int COLS    = 3,
    parameter int NUM_OUT = 2,
    parameter int OUT_SEL = 0,
    parameter bit REG_OUT = 1'b1,
    localparam int COL_GW = GENE_W * ROWS,
    localparam int GW     = COL_GW * COLS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GW-1:0]      genotype,
    input  logic [ROWS-1:0]    din,
    output logic [NUM_OUT-1:0] dout
);
    logic [ROWS-1:0]    stage [0:COLS];
    logic [ROWS-1:0]    last_col;
    logic [NUM_OUT-1:0] comb_sel;

    assign stage[0] = din;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        cga_column #(.ROWS(ROWS)) u_col (
            .prev  (stage[c]),
            .genes (genotype[c*COL_GW +: COL_GW]),
            .nxt   (stage[c+1])
        );
    end

    assign last_col = stage[COLS];

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_sel
        localparam int SRC = (OUT_SEL + k) % ROWS;
        assign comb_sel[k] = last_col[SRC];
    end

    cga_out_stage #(.W(NUM_OUT), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (comb_sel),
        .q   (dout)
    );
endmodule

// File: rtl/cga_checker.sv
module cga_checker #(
    parameter int ROWS    = 4,
    parameter int COLS    = 3,
    parameter int NUM_OUT = 2,
    parameter bit REG_OUT = 1'b1,
    localparam int GW     = 3 * ROWS * COLS,
    localparam int SH     = COLS % ROWS
) (
    input logic               clk,
    input logic               rst,
    input logic [GW-1:0]      genotype,
    input logic [ROWS-1:0]    din,
    input logic [ROWS-1:0]    last_col,
    input logic [NUM_OUT-1:0] comb_sel,
    input logic [NUM_OUT-1:0] dout
);
    function automatic logic [GW-1:0] fill_gene(logic [2:0] code);
        logic [GW-1:0] g;
        g = '0;
        for (int i = 0; i < ROWS * COLS; i++) g[3*i +: 3] = code;
        return g;
    endfunction

    localparam logic [GW-1:0] ALL_NBR = fill_gene(3'd1);
    localparam logic [GW-1:0] ALL_AND = fill_gene(3'd6);

    logic [ROWS-1:0] rot_din;
    always_comb begin
        for (int r = 0; r < ROWS; r++) rot_din[r] = din[(r + SH) % ROWS];
    end

    a_r1_pass_own: assert property (@(posedge clk) disable iff (rst)
        (genotype == '0) |-> (last_col == din));

    a_r2_pass_nbr: assert property (@(posedge clk) disable iff (rst)
        (genotype == ALL_NBR) |-> (last_col == rot_din));

    a_r3_and_ones: assert property (@(posedge clk) disable iff (rst)
        (genotype == ALL_AND && din == '1) |-> (last_col == '1));

    if (REG_OUT) begin : g_reg_chk
        a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (dout == $past(comb_sel)));

        a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (dout == '0));
    end
endmodule

bind cga_array cga_checker #(
    .ROWS(ROWS), .COLS(COLS), .NUM_OUT(NUM_OUT), .REG_OUT(REG_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .genotype (genotype),
    .din      (din),
    .last_col (last_col),
    .comb_sel (comb_sel),
    .dout     (dout)
);

// File: tb/sim_cga_array.sv
module sim_cga_array;
    localparam int CLK_P   = 10;
    localparam int ROWS    = 4;
    localparam int COLS    = 3;
    localparam int NUM_OUT = 2;
    localparam int OUT_SEL = 0;
    localparam int GW      = 3 * ROWS * COLS;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [GW-1:0]      genotype = '0;
    logic [ROWS-1:0]    din = '0;
    logic [NUM_OUT-1:0] dout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cga_array #(.ROWS(ROWS), .COLS(COLS), .NUM_OUT(NUM_OUT),
                .OUT_SEL(OUT_SEL), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .genotype(genotype), .din(din), .dout(dout)
    );

    function automatic logic op_eval(logic [2:0] code, logic a, logic b);
        case (code)
            3'd0: return a;
            3'd1: return b;
            3'd2: return a ^ b;
            3'd3: return ~(a ^ b);
            3'd4: return ~(a & b);
            3'd5: return ~(a | b);
            3'd6: return a & b;
            default: return a | b;
        endcase
    endfunction

    function automatic logic [NUM_OUT-1:0] model(logic [GW-1:0] g, logic [ROWS-1:0] d);
        logic [ROWS-1:0] cur, nx;
        logic [NUM_OUT-1:0] o;
        cur = d;
        for (int c = 0; c < COLS; c++) begin
            for (int r = 0; r < ROWS; r++)
                nx[r] = op_eval(g[3*(c*ROWS + r) +: 3], cur[r], cur[(r+1) % ROWS]);
            cur = nx;
        end
        for (int k = 0; k < NUM_OUT; k++) o[k] = cur[(OUT_SEL + k) % ROWS];
        return o;
    endfunction

    task automatic chk(string req, logic [NUM_OUT-1:0] act, logic [NUM_OUT-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(logic [GW-1:0] g, logic [ROWS-1:0] d);
        @(negedge clk);
        genotype = g;
        din = d;
        @(negedge clk);
    endtask

    function automatic logic [GW-1:0] rand_geno();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[GW-1:0];
    endfunction

    function automatic logic [GW-1:0] fill(logic [2:0] code);
        logic [GW-1:0] g;
        g = '0;
        for (int i = 0; i < ROWS * COLS; i++) g[3*i +: 3] = code;
        return g;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [GW-1:0] g;
        logic [ROWS-1:0] d;
        logic [NUM_OUT-1:0] prev;
        void'($urandom(32'd1234));

        // R9: reset state
        din = 4'b1111;
        repeat (2) @(negedge clk);
        chk("R9 reset", dout, '0);
        rst = 1'b0;

        // R1 / R7: every gene passes own row; output rows 0 and 1
        for (int i = 0; i < 6; i++) begin
            d = ROWS'($urandom());
            apply('0, d);
            chk("R1 R7 pass-own", dout, d[1:0]);
        end

        // R2 / R4: every gene passes next row, wraps by COLS rows
        for (int v = 0; v < 16; v++) begin
            apply(fill(3'd1), ROWS'(v));
            chk("R2 R4 pass-nbr wrap", dout, {din[(1+COLS)%ROWS], din[COLS%ROWS]});
        end

        // R3: single function cell at last column, row 0 (gene index 8)
        for (int f = 2; f < 8; f++) begin
            for (int v = 0; v < 4; v++) begin
                g = '0;
                g[3*((COLS-1)*ROWS) +: 3] = 3'(f);
                d = ROWS'(v) | 4'b1100;
                apply(g, d);
                chk("R3 function", dout, {d[1], op_eval(3'(f), d[0], d[1])});
            end
        end

        // R5 / R4: column 0 bottom row XOR wraps to din[0], shifted up by later columns
        for (int v = 0; v < 16; v++) begin
            g = fill(3'd1);
            for (int r = 0; r < ROWS; r++) g[3*r +: 3] = 3'd0;
            g[3*(ROWS-1) +: 3] = 3'd2;
            d = ROWS'(v);
            apply(g, d);
            chk("R5 first-column wrap", dout, {d[3] ^ d[0], d[2]});
        end

        // R6: gene 0 sits in bits [2:0] and controls row 0 of column 0
        for (int v = 0; v < 16; v++) begin
            g = '0;
            g[2:0] = 3'd7;
            d = ROWS'(v);
            apply(g, d);
            chk("R6 gene position", dout, {d[1], d[0] | d[1]});
        end

        // R6 / R8: random genotype and input changed together
        for (int i = 0; i < 300; i++) begin
            g = rand_geno();
            d = ROWS'($urandom());
            apply(g, d);
            chk("R6 R8 random", dout, model(g, d));
        end

        // R8: output holds between edges, updates after one edge
        apply('0, 4'b0001);
        prev = dout;
        @(negedge clk);
        din = 4'b0010;
        #1;
        chk("R8 hold before edge", dout, prev);
        @(negedge clk);
        chk("R8 update after edge", dout, 2'b10);

        // R9: mid-run reset clears a nonzero output
        apply('0, 4'b0011);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 mid-run reset", dout, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 release", dout, 2'b11);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule